// File: doc/BRIEF.md
# Split-Read ADC Conversion Sequencer

This block runs a successive-approximation converter over a three-wire serial link. It drives the conversion-start line and a divided serial clock, and it samples the converter's serial data output. Each time the converter holds a result, the block assembles that result into a 16-bit word and presents it with a single-cycle valid strobe. A `start` pulse launches a batch of `num_conv` results. A `done` pulse closes the batch.

The block has two read schemes, chosen per batch by `span_mode`. In the spanning scheme, the upper byte of a result is clocked out as soon as that conversion finishes. The lower byte is clocked out just after the next conversion has been launched, inside a short window in which clock activity cannot disturb the converter. This lets a slow serial clock keep pace with a high conversion rate, at the price of one extra conversion per batch. In the plain scheme, all sixteen bits are read after the conversion ends and before the next one starts.

A single cycle counter times the start pulse and the conversion. The end of a conversion is taken either from that counter or from the converter's busy output, as fixed by the `USE_BUSY` parameter.

Top module: `adcseq_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `adc_cnv`, `adc_sck`, `result_valid` and `done` are all 0. An active batch that is reset returns both converter lines to 0.
- R2: Every conversion start is a high pulse on `adc_cnv` lasting exactly `CNV_HI` system cycles. `adc_sck` is low whenever `adc_cnv` is high.
- R3: While the converter is converting, every rising edge of `adc_sck` comes fewer than `SAFE_WIN` system cycles after the rising edge of `adc_cnv`.
- R4: Within a transfer, rising edges of `adc_sck` are `2*CLK_DIV` system cycles apart. The sck idle level is 0. Data is taken MSB first, on each rising edge.
- R5: With `span_mode`=1, the upper 8 bits (bits 15..8) are read after a conversion ends. The lower 8 bits of the same result are read after the next start pulse. The word is then `hi*256 + lo`. A batch of N results issues N+1 start pulses, and the first conversion yields no word.
- R6: With `span_mode`=0, all 16 bits are read after each conversion ends and before the next start pulse. A batch of N results issues N start pulses.
- R7: With `USE_BUSY`=0, a conversion is taken as ended `CONV_T` cycles after its start. With `USE_BUSY`=1, it is taken as ended once `adc_busy` is seen low after the start pulse.
- R8: `result_valid` is high for one cycle per word. A batch yields exactly N words, in conversion order.
- R9: `done` is a single-cycle pulse, once per batch. In plain mode it coincides with the last `result_valid`. In spanning mode it follows the end of the extra conversion. Both converter lines are low while `done` is high.
- R10: A `start` with `num_conv`=0 raises `done` on the next cycle and issues no start pulse.
- R11: `start`, `span_mode` and `num_conv` are ignored while a batch is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches a batch when idle |
| span_mode | input | 1 | 1 = spanning read, 0 = plain read; latched at start |
| num_conv | input | 16 | Number of results N; latched at start |
| adc_busy | input | 1 | Converter busy flag (used when USE_BUSY=1) |
| adc_sdo | input | 1 | Converter serial data |
| adc_cnv | output | 1 | Conversion start line |
| adc_sck | output | 1 | Serial clock to converter |
| result | output | 16 | Assembled result word |
| result_valid | output | 1 | One-cycle strobe for `result` |
| done | output | 1 | One-cycle end-of-batch pulse |

## Verification
The converter model in the bench returns a distinct, pseudo-random-looking word for each conversion, so a byte that is swapped, shifted or paired with the wrong conversion shows up as a wrong value. Spanning and plain batches of several lengths run against a timer-ended instance and a busy-ended instance. This separates the byte-pairing path from the full-word path, and the counter-based end of conversion from the busy-based end. The model counts any serial clock edge that falls outside the permitted window, and the bench also measures the sck period and counts start pulses per batch. Directed cases cover a zero-length batch, start inputs that change during a batch, and a reset in the middle of a batch.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    localparam int RES_W  = 16;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 16;
    localparam int BIT_W  = $clog2(RES_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CNV,
        ST_LO,
        ST_WAIT,
        ST_READ
    } seq_state_e;

    typedef struct packed {
        logic             span;
        logic [CNT_W-1:0] target;
    } run_cfg_t;

    function automatic logic [RES_W-1:0] join_bytes(input logic [BYTE_W-1:0] hi,
                                                    input logic [BYTE_W-1:0] lo);
        logic [RES_W-1:0] wide_hi;
        wide_hi = RES_W'(hi);
        return (wide_hi << BYTE_W) + RES_W'(lo);
    endfunction

    function automatic logic [BIT_W-1:0] xfer_len(input logic span);
        return span ? BIT_W'(BYTE_W) : BIT_W'(RES_W);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/adcseq_timer.sv
module adcseq_timer
    import adcseq_pkg::*;
#(
    parameter int CNV_HI   = 3,
    parameter int SAFE_WIN = 40,
    parameter int CONV_T   = 60,
    parameter bit USE_BUSY = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic busy_in,
    output logic pulse_done,
    output logic conv_end
);
    localparam int LIM = max3(CNV_HI, SAFE_WIN, CONV_T) + 2;
    localparam int TW  = $clog2(LIM + 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= TW'(LIM);
        end else if (restart) begin
            cnt <= '0;
        end else if (cnt != TW'(LIM)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign pulse_done = (cnt >= TW'(CNV_HI - 1));

    generate
        if (USE_BUSY) begin : g_busy_end
            logic busy_q;
            always_ff @(posedge clk) begin
                if (rst) busy_q <= 1'b0;
                else     busy_q <= busy_in;
            end
            assign conv_end = !busy_q && (cnt >= TW'(CNV_HI + 1));
        end else begin : g_timed_end
            assign conv_end = (cnt >= TW'(CONV_T - 1));
        end
    endgenerate

endmodule

// File: rtl/adcseq_shift.sv
module adcseq_shift
    import adcseq_pkg::*;
#(
    parameter int CLK_DIV = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [BIT_W-1:0] nbits,
    input  logic             sdo,
    output logic             sck,
    output logic             done,
    output logic [RES_W-1:0] data
);
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    logic             active;
    logic [DIV_W-1:0] div;
    logic [BIT_W-1:0] bits;
    logic [BIT_W-1:0] nbits_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            div     <= '0;
            bits    <= '0;
            nbits_q <= '0;
            sck     <= 1'b0;
            done    <= 1'b0;
            data    <= '0;
        end else begin
            done <= 1'b0;
            if (go) begin
                active  <= 1'b1;
                div     <= '0;
                bits    <= '0;
                nbits_q <= nbits;
                sck     <= 1'b0;
                data    <= '0;
            end else if (active) begin
                if (div == DIV_W'(CLK_DIV - 1)) begin
                    div <= '0;
                    if (!sck) begin
                        sck  <= 1'b1;
                        data <= {data[RES_W-2:0], sdo};
                        bits <= bits + 1'b1;
                    end else begin
                        sck <= 1'b0;
                        if (bits == nbits_q) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end
                    end
                end else begin
                    div <= div + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
    import adcseq_pkg::*;
#(
    parameter int CLK_DIV  = 2,
    parameter int CNV_HI   = 3,
    parameter int SAFE_WIN = 40,
    parameter int CONV_T   = 60,
    parameter bit USE_BUSY = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             span_mode,
    input  logic [CNT_W-1:0] num_conv,
    input  logic             adc_busy,
    input  logic             adc_sdo,
    output logic             adc_cnv,
    output logic             adc_sck,
    output logic [RES_W-1:0] result,
    output logic             result_valid,
    output logic             done
);
    seq_state_e        state;
    run_cfg_t          cfg;
    logic [CNT_W-1:0]  res_cnt;
    logic [BYTE_W-1:0] hi_q;
    logic              have_hi;

    logic              restart;
    logic              pulse_done;
    logic              conv_end;
    logic              sh_go;
    logic [BIT_W-1:0]  sh_bits;
    logic              sh_done;
    logic [RES_W-1:0]  sh_data;
    logic              last_word;

    assign last_word = ((res_cnt + 1'b1) == cfg.target);

    adcseq_timer #(
        .CNV_HI  (CNV_HI),
        .SAFE_WIN(SAFE_WIN),
        .CONV_T  (CONV_T),
        .USE_BUSY(USE_BUSY)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .busy_in   (adc_busy),
        .pulse_done(pulse_done),
        .conv_end  (conv_end)
    );

    adcseq_shift #(
        .CLK_DIV(CLK_DIV)
    ) u_shift (
        .clk  (clk),
        .rst  (rst),
        .go   (sh_go),
        .nbits(sh_bits),
        .sdo  (adc_sdo),
        .sck  (adc_sck),
        .done (sh_done),
        .data (sh_data)
    );

    always_comb begin
        restart = 1'b0;
        sh_go   = 1'b0;
        sh_bits = xfer_len(1'b1);
        unique case (state)
            ST_IDLE: restart = start && (num_conv != '0);
            ST_CNV:  sh_go   = pulse_done && cfg.span && have_hi;
            ST_WAIT: begin
                sh_go   = conv_end && (res_cnt != cfg.target);
                sh_bits = xfer_len(cfg.span);
            end
            ST_READ: restart = sh_done && (cfg.span || !last_word);
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            cfg          <= '0;
            res_cnt      <= '0;
            hi_q         <= '0;
            have_hi      <= 1'b0;
            adc_cnv      <= 1'b0;
            result       <= '0;
            result_valid <= 1'b0;
            done         <= 1'b0;
        end else begin
            result_valid <= 1'b0;
            done         <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (num_conv == '0) begin
                            done <= 1'b1;
                        end else begin
                            cfg     <= '{span: span_mode, target: num_conv};
                            res_cnt <= '0;
                            have_hi <= 1'b0;
                            adc_cnv <= 1'b1;
                            state   <= ST_CNV;
                        end
                    end
                end
                ST_CNV: begin
                    if (pulse_done) begin
                        adc_cnv <= 1'b0;
                        state   <= sh_go ? ST_LO : ST_WAIT;
                    end
                end
                ST_LO: begin
                    if (sh_done) begin
                        result       <= join_bytes(hi_q, sh_data[BYTE_W-1:0]);
                        result_valid <= 1'b1;
                        res_cnt      <= res_cnt + 1'b1;
                        state        <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (conv_end) begin
                        if (res_cnt == cfg.target) begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            state <= ST_READ;
                        end
                    end
                end
                ST_READ: begin
                    if (sh_done) begin
                        if (cfg.span) begin
                            hi_q    <= sh_data[BYTE_W-1:0];
                            have_hi <= 1'b1;
                            adc_cnv <= 1'b1;
                            state   <= ST_CNV;
                        end else begin
                            result       <= sh_data;
                            result_valid <= 1'b1;
                            res_cnt      <= res_cnt + 1'b1;
                            if (last_word) begin
                                done  <= 1'b1;
                                state <= ST_IDLE;
                            end else begin
                                adc_cnv <= 1'b1;
                                state   <= ST_CNV;
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk #(
    parameter int CNV_HI   = 3,
    parameter int SAFE_WIN = 40,
    parameter int CONV_T   = 60,
    parameter bit USE_BUSY = 1'b0
) (
    input logic clk,
    input logic rst,
    input logic adc_cnv,
    input logic adc_sck,
    input logic adc_busy,
    input logic result_valid,
    input logic done
);
    logic [15:0] hi_len;
    logic [15:0] age;
    logic        cnv_q;
    logic        converting;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_len <= '0;
            age    <= '0;
            cnv_q  <= 1'b0;
        end else begin
            cnv_q  <= adc_cnv;
            hi_len <= adc_cnv ? hi_len + 1'b1 : '0;
            if (adc_cnv && !cnv_q)  age <= 16'd1;
            else if (age != 16'hFFFF) age <= age + 1'b1;
        end
    end

    assign converting = USE_BUSY ? adc_busy : (age < 16'(CONV_T));

    AST_CNV_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_cnv) |-> (hi_len == 16'(CNV_HI)));                   // R2
    AST_SCK_LOW_IN_CNV: assert property (@(posedge clk) disable iff (rst)
        adc_cnv |-> !adc_sck);                                         // R2
    AST_SCK_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        ($rose(adc_sck) && converting) |-> (age < 16'(SAFE_WIN)));     // R3
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);                               // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                               // R9
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done |-> (!adc_cnv && !adc_sck));                              // R9

endmodule

bind adcseq_top adcseq_chk #(
    .CNV_HI  (CNV_HI),
    .SAFE_WIN(SAFE_WIN),
    .CONV_T  (CONV_T),
    .USE_BUSY(USE_BUSY)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .adc_cnv     (adc_cnv),
    .adc_sck     (adc_sck),
    .adc_busy    (adc_busy),
    .result_valid(result_valid),
    .done        (done)
);

// File: tb/adcseq_top_tb_top.sv
`timescale 1ns/1ps

module adcseq_adc_model #(
    parameter int CONV_CYC = 52,
    parameter int SAFE_CYC = 40
) (
    input  logic clk,
    input  logic cnv,
    input  logic sck,
    output logic sdo,
    output logic busy,
    output int   starts,
    output int   ends,
    output int   viol
);
    function automatic logic [15:0] word_of(input int k);
        return 16'((k * 40503 + 4660) & 32'hFFFF);
    endfunction

    logic [15:0] word  = '0;
    int          falls = 0;
    int          base  = 0;
    int          age   = 0;
    int          n_st  = 0;
    int          n_en  = 0;
    int          n_vi  = 0;
    bit          conv  = 0;
    logic        bsy   = 0;
    logic        cnv_q = 0;
    int          idx;

    assign starts = n_st;
    assign ends   = n_en;
    assign viol   = n_vi;
    assign busy   = bsy;
    assign idx    = falls - base;
    assign sdo    = (idx >= 0 && idx < 16) ? word[4'(15 - idx)] : 1'b0;

    always @(negedge clk) begin
        cnv_q <= cnv;
        if (cnv && !cnv_q) begin
            conv <= 1;
            bsy  <= 1'b1;
            age  <= 0;
            n_st <= n_st + 1;
        end else if (conv) begin
            age <= age + 1;
            if (age + 1 >= CONV_CYC) begin
                conv <= 0;
                bsy  <= 1'b0;
                word <= word_of(n_en);
                base <= falls;
                n_en <= n_en + 1;
            end
        end
    end

    always @(posedge sck) if (cnv || (conv && age >= SAFE_CYC)) n_vi <= n_vi + 1;
    always @(negedge sck) falls <= falls + 1;
endmodule

module adcseq_top_tb_top;
    localparam int CLK_DIV  = 2;
    localparam int CNV_HI   = 3;
    localparam int SAFE_WIN = 40;
    localparam int CONV_T   = 60;
    localparam int MODEL_T  = 52;

    // vector: {instance select, span mode, 8-bit result count}
    localparam logic [9:0] VEC [6] = '{
        {1'b0, 1'b1, 8'd3}, {1'b0, 1'b0, 8'd3}, {1'b1, 1'b1, 8'd4},
        {1'b1, 1'b0, 8'd2}, {1'b0, 1'b1, 8'd1}, {1'b1, 1'b0, 8'd1}
    };

    function automatic logic [15:0] word_of(input int k);
        return 16'((k * 40503 + 4660) & 32'hFFFF);
    endfunction

    logic clk = 0;
    logic rst = 1;
    always #5 clk = ~clk;

    logic        start_t = 0, start_b = 0, span = 0;
    logic [15:0] num = '0;
    logic        busy_t, sdo_t, cnv_t, sck_t, val_t, done_t;
    logic        busy_b, sdo_b, cnv_b, sck_b, val_b, done_b;
    logic [15:0] res_t, res_b;
    int          st_t, en_t, vi_t, st_b, en_b, vi_b;

    adcseq_top #(.CLK_DIV(CLK_DIV), .CNV_HI(CNV_HI), .SAFE_WIN(SAFE_WIN),
                 .CONV_T(CONV_T), .USE_BUSY(1'b0)) dut_i (
        .clk(clk), .rst(rst), .start(start_t), .span_mode(span), .num_conv(num),
        .adc_busy(busy_t), .adc_sdo(sdo_t), .adc_cnv(cnv_t), .adc_sck(sck_t),
        .result(res_t), .result_valid(val_t), .done(done_t));
    adcseq_adc_model #(.CONV_CYC(MODEL_T), .SAFE_CYC(SAFE_WIN)) mdl_t (
        .clk(clk), .cnv(cnv_t), .sck(sck_t), .sdo(sdo_t), .busy(busy_t),
        .starts(st_t), .ends(en_t), .viol(vi_t));

    adcseq_top #(.CLK_DIV(CLK_DIV), .CNV_HI(CNV_HI), .SAFE_WIN(SAFE_WIN),
                 .CONV_T(CONV_T), .USE_BUSY(1'b1)) dut_b (
        .clk(clk), .rst(rst), .start(start_b), .span_mode(span), .num_conv(num),
        .adc_busy(busy_b), .adc_sdo(sdo_b), .adc_cnv(cnv_b), .adc_sck(sck_b),
        .result(res_b), .result_valid(val_b), .done(done_b));
    adcseq_adc_model #(.CONV_CYC(MODEL_T), .SAFE_CYC(SAFE_WIN)) mdl_b (
        .clk(clk), .cnv(cnv_b), .sck(sck_b), .sdo(sdo_b), .busy(busy_b),
        .starts(st_b), .ends(en_b), .viol(vi_b));

    // output monitor, index 0 = timer-ended, 1 = busy-ended
    logic [1:0]  val_w, done_w, sck_w;
    logic [15:0] res_w [2];
    assign val_w  = {val_b, val_t};
    assign done_w = {done_b, done_t};
    assign sck_w  = {sck_b, sck_t};
    assign res_w[0] = res_t;
    assign res_w[1] = res_b;

    logic [15:0] rec [2][64];
    int nrec [2] = '{0, 0};
    int ndone[2] = '{0, 0};
    int ndwv [2] = '{0, 0};
    int nbad [2] = '{0, 0};
    int lastr[2] = '{-1000, -1000};
    logic [1:0] sck_p = '0;
    int cyc = 0;

    always @(negedge clk) begin
        cyc   <= cyc + 1;
        sck_p <= sck_w;
        for (int k = 0; k < 2; k++) begin
            if (val_w[k]) begin
                rec[k][nrec[k] % 64] <= res_w[k];
                nrec[k] <= nrec[k] + 1;
            end
            if (done_w[k]) ndone[k] <= ndone[k] + 1;
            if (done_w[k] && val_w[k]) ndwv[k] <= ndwv[k] + 1;
            if (sck_w[k] && !sck_p[k]) begin
                if ((cyc - lastr[k]) < 4 * CLK_DIV && (cyc - lastr[k]) != 2 * CLK_DIV)
                    nbad[k] <= nbad[k] + 1;
                lastr[k] <= cyc;
            end
        end
    end

    int errors = 0;
    int checks = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_case(input int sel, input bit sp, input int n, input bit poke);
        int r0, d0, w0, b0, e0, s0, v0;
        string rq;
        rq = sp ? "R5" : "R6";
        r0 = nrec[sel]; d0 = ndone[sel]; w0 = ndwv[sel]; b0 = nbad[sel];
        e0 = sel ? en_b : en_t; s0 = sel ? st_b : st_t; v0 = sel ? vi_b : vi_t;
        span = sp; num = 16'(n);
        @(negedge clk);
        if (sel != 0) start_b = 1; else start_t = 1;
        @(negedge clk);
        start_t = 0; start_b = 0;
        if (poke) begin
            // R11: a second start with other settings during the batch
            repeat (20) @(negedge clk);
            span = ~sp; num = 16'd7;
            if (sel != 0) start_b = 1; else start_t = 1;
            @(negedge clk);
            start_t = 0; start_b = 0;
        end
        for (int c = 0; c < 20000 && ndone[sel] == d0; c++) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(nrec[sel] - r0 == n, "R8", "word count", nrec[sel] - r0, n);
        for (int i = 0; i < n && i < nrec[sel] - r0; i++)
            chk(rec[sel][(r0 + i) % 64] == word_of(e0 + i), rq, "word value",
                int'(rec[sel][(r0 + i) % 64]), int'(word_of(e0 + i)));
        chk(((sel ? st_b : st_t) - s0) == (sp ? n + 1 : n), rq, "start pulses",
            (sel ? st_b : st_t) - s0, sp ? n + 1 : n);
        chk(((sel ? vi_b : vi_t) - v0) == 0, "R3", "sck edges outside window",
            (sel ? vi_b : vi_t) - v0, 0);
        chk(nbad[sel] - b0 == 0, "R4", "bad sck periods", nbad[sel] - b0, 0);
        chk(ndone[sel] - d0 == 1, sel ? "R7" : "R9", "done pulses", ndone[sel] - d0, 1);
        chk(ndwv[sel] - w0 == (sp ? 0 : 1), "R9", "done with last valid",
            ndwv[sel] - w0, sp ? 0 : 1);
        if (poke)
            chk(((sel ? st_b : st_t) - s0) == n + 1, "R11", "restart ignored",
                (sel ? st_b : st_t) - s0, n + 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R9 watchdog expired: actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({cnv_t, sck_t, val_t, done_t, cnv_b, sck_b, val_b, done_b} == 8'h00,
            "R1", "outputs in reset", int'({cnv_t, sck_t, val_t, done_t}), 0);
        rst = 0;
        @(negedge clk);
        chk({cnv_t, sck_t, val_t, done_t} == 4'h0, "R1", "outputs after reset",
            int'({cnv_t, sck_t, val_t, done_t}), 0);

        for (int v = 0; v < 6; v++)
            run_case(int'(VEC[v][9]), VEC[v][8], int'(VEC[v][7:0]), 1'b0);

        // R10: zero-length batch
        begin
            int s0;
            s0 = st_t;
            num = 16'd0;
            @(negedge clk); start_t = 1;
            @(negedge clk); start_t = 0;
            chk(done_t == 1'b1, "R10", "done after empty start", int'(done_t), 1);
            @(negedge clk);
            chk(done_t == 1'b0, "R10", "done single cycle", int'(done_t), 0);
            chk(st_t == s0, "R10", "no start pulse", st_t - s0, 0);
        end

        run_case(0, 1'b1, 2, 1'b1);

        // R1: reset during a batch
        num = 16'd3; span = 1'b0;
        @(negedge clk); start_t = 1;
        @(negedge clk); start_t = 0;
        repeat (30) @(negedge clk);
        rst = 1;
        @(negedge clk);
        chk({cnv_t, sck_t, val_t, done_t} == 4'h0, "R1", "reset mid-batch",
            int'({cnv_t, sck_t, val_t, done_t}), 0);
        rst = 0;
        repeat (100) @(negedge clk);
        run_case(0, 1'b1, 2, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule